// File: doc/BRIEF.md
# SPI Master Register and Interrupt Unit

This block is the processor-facing side of an SPI master controller. A simple 32-bit peripheral bus reaches it through an address, a write strobe, a read strobe, write data and combinational read data. Inside are the settings registers (configuration, controller enable, delay and slave idle count), a byte transmit FIFO fed by bus writes, and a byte receive FIFO drained by bus reads. The serial shift engine sits outside the block. It pulls transmit bytes, pushes received bytes and reports mode faults through plain strobes and level flags.

Seven interrupt sources are collected in one status word. Event sources latch and are acknowledged by writing ones to the status address. Level sources follow the FIFO state directly. A mask register is built up and torn down through separate set-only and clear-only addresses. The interrupt line is the OR of the masked status. The TX watermark register is exactly wide enough to hold depth−1, so software can find the FIFO depth by writing all ones and reading the value back.

The configuration the engine sees is captured only when the controller enable goes from off to on. Software therefore changes settings with the controller off and applies them by turning it back on.

Top module: `spi_regif`

## Requirements
- R1: After reset the configuration, enable, delay, idle-count and mask registers read 0. The watermark reads 1. Every latched status bit is 0, `irq` is low and `ctl_cfg` is 0.
- R2: Configuration (0x00) and delay (0x18) are 32-bit read/write. Idle count (0x24) keeps its low `IDLE_W` bits. The mask view (0x10) is read-only, and a write to it changes nothing.
- R3: The watermark (0x28) keeps only log2(`DEPTH`) bits. Writing 0xFFFF reads back `DEPTH`−1, and any other write reads back its low bits.
- R4: Each write to the transmit address (0x1C) queues `bus_wdata[7:0]`, and the engine receives the bytes in write order. A write while `DEPTH` bytes are already queued is dropped.
- R5: Each read of the receive address (0x20) returns the oldest received byte in bits 7:0 and removes it. A read of an empty receive FIFO returns 0.
- R6: Writing ones to 0x08 sets those mask bits, and writing ones to 0x0C clears them. Both addresses read as 0. The mask is read at 0x10 with the same bit layout as the status.
- R7: Status bit 0 (receive overrun: engine push while the RX FIFO is full, byte dropped), bit 1 (mode fault) and bit 6 (transmit underflow: engine pull while the TX FIFO is empty) latch on their event. They clear only when a one is written to the same bit of 0x04. A zero written leaves them set.
- R8: Status bit 2 is 1 while the TX fill is below the watermark. Bit 3 is 1 while the TX FIFO is full. Bit 4 is 1 while the RX FIFO is not empty. Bit 5 is 1 while the RX FIFO is full. Writes to 0x04 have no effect on these four bits.
- R9: `irq` is high exactly when some status bit and the same mask bit are both 1.
- R10: The enable register (0x14) stores only bit 0 and drives `ctl_enable`. `ctl_cfg` takes the configuration register value only on a write that turns enable from 0 to 1. Configuration writes made while enabled do not reach `ctl_cfg`.
- R11: `ctl_delay` and `ctl_idle` show the delay and idle-count registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops RX FIFO at 0x20) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_byte | output | 8 | Head transmit byte (0 when empty) |
| eng_tx_empty | output | 1 | Transmit FIFO empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive FIFO full |
| eng_mode_fault | input | 1 | Mode fault event pulse |
| ctl_enable | output | 1 | Controller enable |
| ctl_cfg | output | 32 | Configuration applied at the last enable |
| ctl_delay | output | 32 | Delay register |
| ctl_idle | output | IDLE_W | Slave idle count |

## Verification
The bench runs a four-entry FIFO through every fill level from empty to two writes past full. At each step it checks the watermark and full bits against counts worked out in the bench, so a design that let a write through when full would return the extra byte to the engine. Under- and overflow of both FIFOs are driven on purpose. A design that dropped the sticky latch would lose those events, and one that treated the acknowledge as a plain write would wrongly clear the level bits. The watermark probe with all ones catches a register that is too wide. The enable off-to-on sequence catches a design that passes configuration writes straight through while the controller runs.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

   localparam int NIRQ = 7;

   // register byte offsets
   localparam logic [7:0] OFS_CFG  = 8'h00;
   localparam logic [7:0] OFS_STAT = 8'h04;
   localparam logic [7:0] OFS_MSET = 8'h08;
   localparam logic [7:0] OFS_MCLR = 8'h0C;
   localparam logic [7:0] OFS_MASK = 8'h10;
   localparam logic [7:0] OFS_EN   = 8'h14;
   localparam logic [7:0] OFS_DLY  = 8'h18;
   localparam logic [7:0] OFS_TXD  = 8'h1C;
   localparam logic [7:0] OFS_RXD  = 8'h20;
   localparam logic [7:0] OFS_IDLE = 8'h24;
   localparam logic [7:0] OFS_WM   = 8'h28;

   // status bit positions
   localparam int IB_RXOVR  = 0;
   localparam int IB_MODF   = 1;
   localparam int IB_TXLOW  = 2;
   localparam int IB_TXFULL = 3;
   localparam int IB_RXNE   = 4;
   localparam int IB_RXFULL = 5;
   localparam int IB_TXUNDR = 6;

   // bits that mirror a level instead of latching an event
   localparam logic [NIRQ-1:0] LIVE_BITS = 7'b0111100;

   typedef struct packed {
      logic cfg;
      logic stat;
      logic mset;
      logic mclr;
      logic en;
      logic dly;
      logic txd;
      logic idle;
      logic wm;
   } wr_sel_t;

endpackage

// File: rtl/spi_regif_fifo.sv
module spi_regif_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       full,
   output logic                       empty,
   output logic [$clog2(DEPTH):0]     level,
   output logic                       ovf,
   output logic                       udf
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = AW + 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [LW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign ovf     = push && full;
   assign udf     = pop && empty;
   assign level   = cnt;
   assign dout    = empty ? '0 : mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LW'(DEPTH)); // R4
   AST_FIFO_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == LW'(DEPTH))); // R4
   AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty); // R5

endmodule

// File: rtl/spi_regif_irq.sv
module spi_regif_irq #(
   parameter int          NB   = 7,
   parameter logic [NB-1:0] LIVE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] src,
   input  logic [NB-1:0] ack,
   input  logic [NB-1:0] mset,
   input  logic [NB-1:0] mclr,
   output logic [NB-1:0] status,
   output logic [NB-1:0] mask,
   output logic          irq
);
   logic [NB-1:0] st_q;
   logic [NB-1:0] ack_eff;

   assign ack_eff = ack & ~LIVE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         mask   <= '0;
      end else begin
         st_q <= ((st_q & ~ack_eff) | src) & ~LIVE;
         mask <= (mask | mset) & ~mclr;
      end
   end

   assign status = (src & LIVE) | st_q;
   assign irq    = |(status & mask);

   genvar gi;
   generate
      for (gi = 0; gi < NB; gi++) begin : g_bit
         if (!LIVE[gi]) begin : g_sticky
            AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
               src[gi] |=> status[gi]); // R7
            AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
               (status[gi] && !ack[gi]) |=> status[gi]); // R7
         end else begin : g_live
            AST_LIVE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
               !src[gi] |-> !status[gi]); // R8
         end
      end
   endgenerate

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|mset) |=> ((mask & $past(mset & ~mclr)) == $past(mset & ~mclr))); // R6
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (|mclr) |=> ((mask & $past(mclr)) == '0)); // R6
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq); // R9

endmodule

// File: rtl/spi_regif.sv
module spi_regif #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 8,
   parameter int IDLE_W = 8,
   parameter int BYTE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq,
   input  logic               eng_tx_pop,
   output logic [BYTE_W-1:0]  eng_tx_byte,
   output logic               eng_tx_empty,
   input  logic               eng_rx_push,
   input  logic [BYTE_W-1:0]  eng_rx_byte,
   output logic               eng_rx_full,
   input  logic               eng_mode_fault,
   output logic               ctl_enable,
   output logic [31:0]        ctl_cfg,
   output logic [31:0]        ctl_delay,
   output logic [IDLE_W-1:0]  ctl_idle
);
   import spi_regif_pkg::*;

   localparam int WMW = $clog2(DEPTH);
   localparam int LW  = WMW + 1;

   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MSET);
   localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MCLR);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
   localparam logic [ADDR_W-1:0] A_DLY  = ADDR_W'(OFS_DLY);
   localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFS_TXD);
   localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFS_RXD);
   localparam logic [ADDR_W-1:0] A_IDLE = ADDR_W'(OFS_IDLE);
   localparam logic [ADDR_W-1:0] A_WM   = ADDR_W'(OFS_WM);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > 256) begin : g_bad_depth
         $error("spi_regif: DEPTH must be a power of two in 2..256");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("spi_regif: ADDR_W must cover offset 0x28");
      end
      if (IDLE_W < 1 || IDLE_W > 32) begin : g_bad_idle
         $error("spi_regif: IDLE_W must be 1..32");
      end
      if (BYTE_W < 1 || BYTE_W > 32) begin : g_bad_byte
         $error("spi_regif: BYTE_W must be 1..32");
      end
   endgenerate

   wr_sel_t           ws;
   logic [31:0]       cfg_q, dly_q;
   logic [IDLE_W-1:0] idle_q;
   logic [WMW-1:0]    wm_q;
   logic              en_q;

   logic [BYTE_W-1:0] rx_dout;
   logic              tx_full, rx_empty;
   logic [LW-1:0]     tx_lvl, rx_lvl;
   logic              tx_ovf, tx_udf, rx_ovf, rx_udf;
   logic              rx_pop;

   logic [NIRQ-1:0]   irq_src, irq_stat, irq_mask;
   logic [NIRQ-1:0]   ack_v, mset_v, mclr_v;

   // write decode
   always_comb begin
      ws      = '0;
      ws.cfg  = bus_wr && (bus_addr == A_CFG);
      ws.stat = bus_wr && (bus_addr == A_STAT);
      ws.mset = bus_wr && (bus_addr == A_MSET);
      ws.mclr = bus_wr && (bus_addr == A_MCLR);
      ws.en   = bus_wr && (bus_addr == A_EN);
      ws.dly  = bus_wr && (bus_addr == A_DLY);
      ws.txd  = bus_wr && (bus_addr == A_TXD);
      ws.idle = bus_wr && (bus_addr == A_IDLE);
      ws.wm   = bus_wr && (bus_addr == A_WM);
   end

   assign rx_pop = bus_rd && (bus_addr == A_RXD);

   // settings registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         dly_q   <= '0;
         idle_q  <= '0;
         wm_q    <= WMW'(1);
         en_q    <= 1'b0;
         ctl_cfg <= '0;
      end else begin
         if (ws.cfg)  cfg_q  <= bus_wdata;
         if (ws.dly)  dly_q  <= bus_wdata;
         if (ws.idle) idle_q <= bus_wdata[IDLE_W-1:0];
         if (ws.wm)   wm_q   <= bus_wdata[WMW-1:0];
         if (ws.en) begin
            en_q <= bus_wdata[0];
            if (bus_wdata[0] && !en_q) ctl_cfg <= cfg_q;
         end
      end
   end

   assign ctl_enable = en_q;
   assign ctl_delay  = dly_q;
   assign ctl_idle   = idle_q;

   // data queues
   spi_regif_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ws.txd),
      .din   (bus_wdata[BYTE_W-1:0]),
      .pop   (eng_tx_pop),
      .dout  (eng_tx_byte),
      .full  (tx_full),
      .empty (eng_tx_empty),
      .level (tx_lvl),
      .ovf   (tx_ovf),
      .udf   (tx_udf)
   );

   spi_regif_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (eng_rx_push),
      .din   (eng_rx_byte),
      .pop   (rx_pop),
      .dout  (rx_dout),
      .full  (eng_rx_full),
      .empty (rx_empty),
      .level (rx_lvl),
      .ovf   (rx_ovf),
      .udf   (rx_udf)
   );

   // interrupt sources
   always_comb begin
      irq_src            = '0;
      irq_src[IB_RXOVR]  = rx_ovf;
      irq_src[IB_MODF]   = eng_mode_fault;
      irq_src[IB_TXLOW]  = (tx_lvl < {1'b0, wm_q});
      irq_src[IB_TXFULL] = tx_full;
      irq_src[IB_RXNE]   = !rx_empty;
      irq_src[IB_RXFULL] = eng_rx_full;
      irq_src[IB_TXUNDR] = tx_udf;
   end

   assign ack_v  = ws.stat ? bus_wdata[NIRQ-1:0] : '0;
   assign mset_v = ws.mset ? bus_wdata[NIRQ-1:0] : '0;
   assign mclr_v = ws.mclr ? bus_wdata[NIRQ-1:0] : '0;

   spi_regif_irq #(.NB(NIRQ), .LIVE(LIVE_BITS)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (irq_src),
      .ack    (ack_v),
      .mset   (mset_v),
      .mclr   (mclr_v),
      .status (irq_stat),
      .mask   (irq_mask),
      .irq    (irq)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CFG)  bus_rdata = cfg_q;
      if (bus_addr == A_STAT) bus_rdata = 32'(irq_stat);
      if (bus_addr == A_MASK) bus_rdata = 32'(irq_mask);
      if (bus_addr == A_EN)   bus_rdata = 32'(en_q);
      if (bus_addr == A_DLY)  bus_rdata = dly_q;
      if (bus_addr == A_RXD)  bus_rdata = 32'(rx_dout);
      if (bus_addr == A_IDLE) bus_rdata = 32'(idle_q);
      if (bus_addr == A_WM)   bus_rdata = 32'(wm_q);
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(ctl_cfg)); // R10
   AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && rx_empty) |-> (bus_rdata == '0)); // R5
   AST_TX_OVF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !eng_tx_pop) |=> tx_full); // R4
   AST_RX_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |=> irq_stat[IB_RXOVR]); // R7
   AST_NO_RX_UNDERRUN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rx_udf |=> (rx_lvl == '0 || $past(eng_rx_push))); // R5

endmodule

// File: tb/sim_spi_regif.sv
module sim_spi_regif;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        eng_tx_pop = 1'b0;
   logic [7:0]  eng_tx_byte;
   logic        eng_tx_empty;
   logic        eng_rx_push = 1'b0;
   logic [7:0]  eng_rx_byte = '0;
   logic        eng_rx_full;
   logic        eng_mode_fault = 1'b0;
   logic        ctl_enable;
   logic [31:0] ctl_cfg, ctl_delay;
   logic [7:0]  ctl_idle;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   spi_regif #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte),
      .eng_tx_empty(eng_tx_empty), .eng_rx_push(eng_rx_push),
      .eng_rx_byte(eng_rx_byte), .eng_rx_full(eng_rx_full),
      .eng_mode_fault(eng_mode_fault), .ctl_enable(ctl_enable),
      .ctl_cfg(ctl_cfg), .ctl_delay(ctl_delay), .ctl_idle(ctl_idle)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic tx_pull(output logic [7:0] v);
      @(negedge clk);
      v = eng_tx_byte; eng_tx_pop = 1'b1;
      @(negedge clk);
      eng_tx_pop = 1'b0;
   endtask

   task automatic rx_give(input logic [7:0] b);
      @(negedge clk);
      eng_rx_byte = b; eng_rx_push = 1'b1;
      @(negedge clk);
      eng_rx_push = 1'b0;
   endtask

   task automatic fault_pulse();
      @(negedge clk);
      eng_mode_fault = 1'b1;
      @(negedge clk);
      eng_mode_fault = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (R1..) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  b;
      int lvl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      brd(8'h00, v); check("R1 cfg", v, 0);
      brd(8'h14, v); check("R1 enable", v, 0);
      brd(8'h10, v); check("R1 mask", v, 0);
      brd(8'h28, v); check("R1 watermark", v, 1);
      brd(8'h04, v); check("R1 status (only tx-low live)", v, 32'h04);
      check("R1 irq", 32'(irq), 0);
      check("R1 ctl_cfg", ctl_cfg, 0);

      // R2 / R11 plain registers
      bwr(8'h00, 32'hA5A5_1234); brd(8'h00, v); check("R2 cfg rw", v, 32'hA5A5_1234);
      bwr(8'h18, 32'hDEAD_BEEF); brd(8'h18, v); check("R2 delay rw", v, 32'hDEAD_BEEF);
      check("R11 ctl_delay", ctl_delay, 32'hDEAD_BEEF);
      bwr(8'h24, 32'h0000_01FF); brd(8'h24, v); check("R2 idle width", v, 32'hFF);
      check("R11 ctl_idle", 32'(ctl_idle), 32'hFF);
      bwr(8'h10, 32'h7F); brd(8'h10, v); check("R2 mask view read-only", v, 0);
      check("R10 cfg not applied while disabled", ctl_cfg, 0);

      // R3 watermark width
      bwr(8'h28, 32'hFFFF); brd(8'h28, v); check("R3 depth probe", v, DEPTH - 1);
      bwr(8'h28, 32'h6); brd(8'h28, v); check("R3 low bits kept", v, 2);

      // R4 / R8 fill sweep, watermark = 2
      for (int k = 1; k <= DEPTH + 2; k++) begin
         bwr(8'h1C, 32'hFFFF_FF00 | 32'(8'h30 + k - 1));
         lvl = (k < DEPTH) ? k : DEPTH;
         brd(8'h04, v);
         check("R8 tx below watermark", 32'(v[2]), 32'(lvl < 2));
         check("R8 tx full", 32'(v[3]), 32'(lvl == DEPTH));
      end
      bwr(8'h04, 32'h08); brd(8'h04, v); check("R8 ack ignored on full", 32'(v[3]), 1);
      for (int k = 0; k < DEPTH; k++) begin
         tx_pull(b); check("R4 tx order", 32'(b), 32'(8'h30 + k));
      end
      check("R4 overflow bytes dropped", 32'(eng_tx_empty), 1);
      tx_pull(b);
      brd(8'h04, v); check("R7 tx underflow latched", 32'(v[6]), 1);

      // R7 acknowledge behaviour
      bwr(8'h04, 32'h0); brd(8'h04, v); check("R7 zero write keeps", 32'(v[6]), 1);
      bwr(8'h04, 32'h40); brd(8'h04, v); check("R7 w1c clears", 32'(v[6]), 0);
      fault_pulse();
      brd(8'h04, v); check("R7 mode fault latched", 32'(v[1]), 1);
      bwr(8'h04, 32'h04); brd(8'h04, v);
      check("R7 other ack keeps fault", 32'(v[1]), 1);
      check("R8 live bit untouched by ack", 32'(v[2]), 1);
      bwr(8'h04, 32'h02); brd(8'h04, v); check("R7 fault cleared", 32'(v[1]), 0);

      // R5 receive path
      for (int k = 0; k <= DEPTH; k++) rx_give(8'hA0 + 8'(k));
      brd(8'h04, v);
      check("R8 rx full", 32'(v[5]), 1);
      check("R7 rx overrun", 32'(v[0]), 1);
      for (int k = 0; k < DEPTH; k++) begin
         brd(8'h20, v); check("R5 rx order", v, 32'(8'hA0 + k));
         brd(8'h04, v); check("R5 rx not-empty", 32'(v[4]), 32'(k < DEPTH - 1));
      end
      brd(8'h20, v); check("R5 empty read zero", v, 0);
      bwr(8'h04, 32'h01); brd(8'h04, v); check("R7 overrun cleared", v, 32'h04);

      // R6 / R9 mask and interrupt line
      check("R9 irq idle", 32'(irq), 0);
      bwr(8'h08, 32'h12); brd(8'h10, v); check("R6 mask set", v, 32'h12);
      brd(8'h08, v); check("R6 set addr reads 0", v, 0);
      brd(8'h0C, v); check("R6 clear addr reads 0", v, 0);
      check("R9 masked bits inactive", 32'(irq), 0);
      rx_give(8'h55); check("R9 irq on rx", 32'(irq), 1);
      bwr(8'h0C, 32'h10); brd(8'h10, v); check("R6 mask clear", v, 32'h02);
      check("R9 irq drops when unmasked", 32'(irq), 0);
      fault_pulse(); check("R9 irq on fault", 32'(irq), 1);
      bwr(8'h04, 32'h02); check("R9 irq after ack", 32'(irq), 0);
      bwr(8'h08, 32'h04); check("R9 irq live tx low", 32'(irq), 1);
      bwr(8'h0C, 32'h7F); check("R9 irq all masked", 32'(irq), 0);
      brd(8'h20, v); check("R5 leftover byte", v, 32'h55);

      // R10 enable and configuration capture
      bwr(8'h00, 32'h11);
      bwr(8'h14, 32'h1);
      check("R10 cfg applied on enable", ctl_cfg, 32'h11);
      check("R10 ctl_enable", 32'(ctl_enable), 1);
      bwr(8'h00, 32'h22);
      check("R10 cfg held while enabled", ctl_cfg, 32'h11);
      bwr(8'h14, 32'h1);
      check("R10 re-enable no reload", ctl_cfg, 32'h11);
      bwr(8'h14, 32'h0);
      check("R10 disable", 32'(ctl_enable), 0);
      bwr(8'h14, 32'hFFFF_FFFF);
      brd(8'h14, v); check("R10 enable bit0 only", v, 1);
      check("R10 cfg applied after toggle", ctl_cfg, 32'h22);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule